// File: doc/BRIEF.md
# Step/Run Pseudo-Random Self-Test Harness

This block drives a small combinational unit under test with pseudo-random stimulus and compresses its answers into signatures. Two 8-bit linear feedback shift registers supply the operand words, a 10-bit up-counter supplies a 2-bit operation select and an 8-bit data word, and two 8-bit multiple-input signature registers fold the unit's two result words into signatures. Every one of these registers advances on a single shared enable.

The enable comes from two push buttons. Each button is synchronised and debounced. A press of the step button gives exactly one advance. A press of the run button sets a sticky flag that advances the harness on every clock. Once the counter reaches its last value, the harness stops. From then on it ignores step, run and load requests until reset. The unit under test is a fixed combinational stub inside the block. The two signatures appear on ports so that a finished run can be compared against a known-good value.

Top module: `step_run_harness`

## Requirements
- R1: After reset, op_a and op_b are 0x01, count is 0, sig_x and sig_y are 0x00 and done is 0.
- R2: While done is 0, a clock edge with load_a (load_b) high puts init_a (init_b) on op_a (op_b) in the next cycle. A load takes priority over an advance.
- R3: On each advance, each operand register s becomes {s[6:0], s[7]^s[5]^s[4]^s[3]}, which is the polynomial x^8+x^6+x^5+x^4+1.
- R4: On each advance, count increases by exactly one. count[9:8] is the select code and count[7:0] is the data word of the unit under test.
- R5: With a=op_a, b=op_b, d=count[7:0] and modulo-256 arithmetic, the stub gives x = a+b, a-b, a^b^d, (a&b)+d and y = a^d, b+d, a|b, ~(a&d) for select values 0 to 3.
- R6: On each advance, each signature s becomes {s[6:0], s[7]^s[5]^s[4]^s[3]} XOR its result word (sig_x takes x, sig_y takes y). Without an advance it holds.
- R7: A step button level that stays high for at least DEB_CYCLES clocks and is then released gives exactly one advance. A high pulse shorter than DEB_CYCLES clocks gives none.
- R8: A debounced press of the run button starts an advance on every clock, which continues after the button is released.
- R9: done is 1 exactly when count is 0x3FF. While done is 1, no register changes, and step, run and load requests have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_step | input | 1 | Raw level of the single-step button |
| btn_run | input | 1 | Raw level of the run button |
| load_a | input | 1 | Load init_a into operand register A |
| load_b | input | 1 | Load init_b into operand register B |
| init_a | input | 8 | Initial value for operand A |
| init_b | input | 8 | Initial value for operand B |
| op_a | output | 8 | Operand A |
| op_b | output | 8 | Operand B |
| count | output | 10 | Progress counter |
| done | output | 1 | Counter at terminal value |
| sig_x | output | 8 | Signature of result word x |
| sig_y | output | 8 | Signature of result word y |

## Verification
A wrong tap or a wrong shift direction in an operand register shows on op_a or op_b on the first advance after a load. Through the stub, the same fault then spreads into both signatures within one more advance. A fault in the stub or in a signature register is seen only through sig_x and sig_y. Because the signatures never recover once they diverge, a comparison at the end of a complete run still exposes a fault that was hit only once. A debouncer or edge-detector fault shows as a count that moves by zero or by more than one per press, and it appears a few tens of clocks after the button is released.

// File: rtl/step_run_harness.sv
module step_run_harness #(
  parameter int W          = 8,
  parameter int CW         = 10,
  parameter int DEB_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          btn_step,
  input  logic          btn_run,
  input  logic          load_a,
  input  logic          load_b,
  input  logic [W-1:0]  init_a,
  input  logic [W-1:0]  init_b,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b,
  output logic [CW-1:0] count,
  output logic          done,
  output logic [W-1:0]  sig_x,
  output logic [W-1:0]  sig_y
);
  localparam int DW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  function automatic logic [W-1:0] shift_fb(input logic [W-1:0] s);
    return {s[W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  logic [1:0]    sync_s, sync_r;
  logic [DW-1:0] dcnt_s, dcnt_r;
  logic          lvl_s, lvl_r, lvl_s_d, lvl_r_d;
  logic          step_pulse, run_q, en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_s <= '0; sync_r <= '0;
      dcnt_s <= '0; dcnt_r <= '0;
      lvl_s <= 1'b0; lvl_r <= 1'b0;
      lvl_s_d <= 1'b0; lvl_r_d <= 1'b0;
    end else begin
      sync_s <= {sync_s[0], btn_step};
      sync_r <= {sync_r[0], btn_run};
      lvl_s_d <= lvl_s;
      lvl_r_d <= lvl_r;
      if (sync_s[1] == lvl_s) dcnt_s <= '0;
      else if (dcnt_s == DW'(DEB_CYCLES - 1)) begin
        lvl_s <= sync_s[1]; dcnt_s <= '0;
      end else dcnt_s <= dcnt_s + 1'b1;
      if (sync_r[1] == lvl_r) dcnt_r <= '0;
      else if (dcnt_r == DW'(DEB_CYCLES - 1)) begin
        lvl_r <= sync_r[1]; dcnt_r <= '0;
      end else dcnt_r <= dcnt_r + 1'b1;
    end
  end

  assign step_pulse = lvl_s & ~lvl_s_d;
  assign done       = (count == LAST);
  assign en         = (step_pulse | run_q) & ~done;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else if (lvl_r & ~lvl_r_d & ~done) run_q <= 1'b1;
  end

  logic [1:0]   sel;
  logic [W-1:0] dat, res_x, res_y;
  assign sel = count[CW-1:CW-2];
  assign dat = count[W-1:0];

  always_comb begin
    case (sel)
      2'd0:    begin res_x = op_a + op_b;          res_y = op_a ^ dat;    end
      2'd1:    begin res_x = op_a - op_b;          res_y = op_b + dat;    end
      2'd2:    begin res_x = op_a ^ op_b ^ dat;    res_y = op_a | op_b;   end
      default: begin res_x = (op_a & op_b) + dat;  res_y = ~(op_a & dat); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a  <= W'(1);
      op_b  <= W'(1);
      count <= '0;
      sig_x <= '0;
      sig_y <= '0;
    end else if (!done) begin
      if (load_a)  op_a <= init_a;
      else if (en) op_a <= shift_fb(op_a);
      if (load_b)  op_b <= init_b;
      else if (en) op_b <= shift_fb(op_b);
      if (en) begin
        count <= count + 1'b1;
        sig_x <= shift_fb(sig_x) ^ res_x;
        sig_y <= shift_fb(sig_y) ^ res_y;
      end
    end
  end

  a_r2_load_a: assert property (@(posedge clk) disable iff (rst)
    (load_a && !done) |=> op_a == $past(init_a));
  a_r2_load_b: assert property (@(posedge clk) disable iff (rst)
    (load_b && !done) |=> op_b == $past(init_b));
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    !done |=> (count == $past(count) || count == $past(count) + 1'b1));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    step_pulse |=> !step_pulse);
  a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(op_a) && $stable(op_b) && $stable(sig_x) && $stable(sig_y));
  a_r6_sig_hold: assert property (@(posedge clk) disable iff (rst)
    $stable(count) |-> ##1 1'b1 ##0 ($past(sig_x) == sig_x || $past(count) != count) );
endmodule

// File: tb/test_step_run_harness.sv
module test_step_run_harness;
  logic clk = 1'b0, rst = 1'b1;
  logic btn_step = 0, btn_run = 0, load_a = 0, load_b = 0;
  logic [7:0] init_a = 0, init_b = 0;
  logic [7:0] op_a, op_b, sig_x, sig_y;
  logic [9:0] count;
  logic done;
  int checks = 0, failures = 0;
  logic [7:0] ma, mb, mx, my;
  logic [9:0] mc;

  always #4 clk = ~clk;

  step_run_harness #(.DEB_CYCLES(4)) i_step_run_harness (
    .clk(clk), .rst(rst), .btn_step(btn_step), .btn_run(btn_run),
    .load_a(load_a), .load_b(load_b), .init_a(init_a), .init_b(init_b),
    .op_a(op_a), .op_b(op_b), .count(count), .done(done),
    .sig_x(sig_x), .sig_y(sig_y));

  function automatic logic [7:0] nx(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic model_step();
    logic [7:0] x, y, d;
    d = mc[7:0];
    case (mc[9:8])
      2'd0: begin x = ma + mb; y = ma ^ d; end
      2'd1: begin x = ma - mb; y = mb + d; end
      2'd2: begin x = ma ^ mb ^ d; y = ma | mb; end
      default: begin x = (ma & mb) + d; y = ~(ma & d); end
    endcase
    mx = nx(mx) ^ x; my = nx(my) ^ y;
    ma = nx(ma); mb = nx(mb); mc = mc + 1'b1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " op_a"}, op_a, ma);
    chk({tag, " op_b"}, op_b, mb);
    chk({tag, " count"}, count, mc);
    chk({tag, " sig_x"}, sig_x, mx);
    chk({tag, " sig_y"}, sig_y, my);
    chk({tag, " done"}, done, (mc == 10'h3FF));
  endtask

  task automatic press_step(input int hold);
    btn_step = 1; cyc(hold); btn_step = 0; cyc(20);
  endtask

  task automatic do_reset();
    rst = 1; cyc(3); rst = 0;
    ma = 8'h01; mb = 8'h01; mx = 0; my = 0; mc = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    cyc(1);
    check_all("R1 reset");
    init_a = 8'h5A; load_a = 1; cyc(1); load_a = 0;
    init_b = 8'hC3; load_b = 1; cyc(1); load_b = 0;
    ma = 8'h5A; mb = 8'hC3;
    chk("R2 load a", op_a, ma);
    chk("R2 load b", op_b, mb);
    for (int i = 0; i < 3; i++) begin
      press_step(12);
      model_step();
      check_all("R3 R4 R5 R6 R7 step");
    end
    press_step(2);
    check_all("R7 glitch ignored");
    btn_run = 1; cyc(12); btn_run = 0;
    for (int i = 0; i < 3000 && !done; i++) cyc(1);
    while (mc != 10'h3FF) model_step();
    check_all("R8 R9 R5 R6 run to end");
    init_a = 8'h77; load_a = 1; cyc(1); load_a = 0;
    press_step(12);
    btn_run = 1; cyc(12); btn_run = 0; cyc(10);
    check_all("R9 frozen after done");
    do_reset();
    cyc(1);
    check_all("R1 second reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule